// File: doc/BRIEF.md
# Partition-Directed Set-Associative Data Cache

This block is a write-back, write-allocate data cache in which every way is also a partition that an individual load or store can name. Each request carries its address, a read/write flag, the store word, a way mask with one bit per way, and a restrict flag. With the restrict flag set, only the masked ways have their tag and data arrays enabled and compared. With it clear, every way is probed. On a miss the new line always goes into one of the masked ways. That lets the instruction stream decide where its data lives and how many arrays each access powers up.

Each response reports hit or miss, the way that served it, the read word, and how many ways the lookup activated. An energy model or a bench can add up that count. Refills and write-backs use a single-beat, whole-line request to a backing memory. The request port takes one access at a time through a valid/ready handshake.

Top module: `part_dcache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req are 0, and every line is invalid, so the first access to any address misses.
- R2: With req_restrict at 1, only the ways whose req_pmask bit is set are activated and compared. resp_ways equals the number of set mask bits. A line held only in an unmasked way gives a miss.
- R3: With req_restrict at 0, all ways are activated (resp_ways equals WAYS). A line held in a way outside the mask still hits. If several active ways match, the lowest-numbered way is used.
- R4: An all-zero req_pmask behaves as if every bit were set, for both lookup and replacement.
- R5: On a miss the filled way is always one of the masked ways. The lowest-numbered invalid masked way is taken first. If none is invalid, the least recently used masked way is taken.
- R6: A hit and a fill both make the touched way the most recently used way of its set. The relative order of the other ways is kept.
- R7: When the chosen victim is valid and dirty, the cache first issues a memory write (mem_we 1) of the old line to the old line address, and only then issues the refill read.
- R8: A store that misses allocates the line, merges the store word into the refilled data and marks the line dirty. Later reads return the stored word.
- R9: req_ready is 1 only while the cache is idle. With memory always ready, resp_valid rises 1 cycle after acceptance on a hit, 2 on a clean miss and 3 on a dirty miss, and the cache is ready again on the next cycle.
- R10: resp_rdata is the addressed 32-bit word of the serving way (the hit way, or the refilled line on a miss), and resp_way gives that way's index.
- R11: Lines are 32 bytes. Address bits [4:2] select the word, the next log2(SETS) bits select the set, and the remaining upper bits form the tag. mem_addr is {tag, set}. Word k of a line sits at mem bits [32k+31:32k]. Requests are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and accepting |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DATA_W | Store word |
| req_pmask | input | WAYS | Partition (way) mask |
| req_restrict | input | 1 | 1 = probe only masked ways |
| resp_valid | output | 1 | Response this cycle |
| resp_hit | output | 1 | 1 = hit, 0 = served by refill |
| resp_rdata | output | DATA_W | Addressed word |
| resp_way | output | log2(WAYS) | Serving way |
| resp_ways | output | log2(WAYS+1) | Ways activated by the lookup |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W-5 | Line address |
| mem_wdata | output | 256 | Line being written back |
| mem_rdata | input | 256 | Refill line |
| mem_ready | input | 1 | Memory completes the transfer this cycle |

## Verification
The bench builds the cache with four ways, two sets and a 12-bit address. With only six tags per set, every set overflows quickly, so victim choice, LRU order among arbitrary subsets of ways, and dirty evictions all occur again and again. A four-bit mask allows all sixteen mask values, zero included, to appear under both settings of the restrict flag. The bench runs a long pseudo-random sweep against an arithmetic shadow of tags, ages, dirty bits and memory. Directed sequences pin down the reset state, the cross-partition hit and miss cases, and the write-back ordering.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } pdc_state_e;

endpackage

// File: rtl/pdc_lookup.sv
module pdc_lookup #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(WAYS),
   localparam int CNT_W = $clog2(WAYS + 1)
) (
   input  logic                         restrict_en,
   input  logic [WAYS-1:0]              emask,
   input  logic [TAG_W-1:0]             look_tag,
   input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
   input  logic [WAYS-1:0]              way_valid,
   input  logic [WAYS-1:0][DATA_W-1:0]  way_word,
   output logic [WAYS-1:0]              act,
   output logic [WAYS-1:0]              hit_vec,
   output logic                         hit,
   output logic [IDX_W-1:0]             hit_way,
   output logic [DATA_W-1:0]            hit_word,
   output logic [CNT_W-1:0]             act_cnt
);

   logic [WAYS-1:0][DATA_W-1:0] gated_word;

   assign act = restrict_en ? emask : {WAYS{1'b1}};

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w]    = act[w] && way_valid[w] && (way_tag[w] == look_tag);
      assign gated_word[w] = act[w] ? way_word[w] : '0;
   end

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            hit     = 1'b1;
            hit_way = IDX_W'(w);
         end
      end
   end

   assign hit_word = gated_word[hit_way];

   always_comb begin
      act_cnt = '0;
      for (int w = 0; w < WAYS; w++) begin
         act_cnt = act_cnt + CNT_W'(act[w]);
      end
   end

endmodule

// File: rtl/pdc_repl.sv
module pdc_repl #(
   parameter int WAYS = 4,
   parameter int SETS = 4,
   localparam int IDX_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS),
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   input  logic [WAYS-1:0]  emask,
   input  logic [WAYS-1:0]  way_valid,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [IDX_W-1:0] touch_way,
   output logic [IDX_W-1:0] victim
);

   logic [AGE_W-1:0] age_q [SETS][WAYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= AGE_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (IDX_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   logic             inv_found;
   logic [IDX_W-1:0] inv_way;
   logic             old_found;
   logic [IDX_W-1:0] old_way;

   always_comb begin
      inv_found = 1'b0;
      inv_way   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (emask[w] && !way_valid[w]) begin
            inv_found = 1'b1;
            inv_way   = IDX_W'(w);
         end
      end
   end

   always_comb begin
      old_found = 1'b0;
      old_way   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (emask[w] && (!old_found || age_q[rd_set][w] > age_q[rd_set][old_way])) begin
            old_found = 1'b1;
            old_way   = IDX_W'(w);
         end
      end
   end

   assign victim = inv_found ? inv_way : old_way;

   assert_touch_mru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> age_q[$past(touch_set)][$past(touch_way)] == '0);

endmodule

// File: rtl/part_dcache.sv
module part_dcache #(
   parameter int WAYS       = 4,
   parameter int SETS       = 4,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int IDX_W  = $clog2(WAYS),
   localparam int CNT_W  = $clog2(WAYS + 1),
   localparam int SET_W  = $clog2(SETS),
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int BYT_W  = $clog2(DATA_W / 8),
   localparam int WORD_W = OFF_W - BYT_W,
   localparam int WORDS  = LINE_BYTES * 8 / DATA_W,
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
   localparam int LA_W   = ADDR_W - OFF_W,
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WAYS-1:0]   req_pmask,
   input  logic              req_restrict,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_rdata,
   output logic [IDX_W-1:0]  resp_way,
   output logic [CNT_W-1:0]  resp_ways,
   output logic              mem_req,
   output logic              mem_we,
   output logic [LA_W-1:0]   mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   import pdc_pkg::*;

   if (!(WAYS == 2 || WAYS == 4 || WAYS == 8)) begin : g_bad_ways
      $error("part_dcache: WAYS must be 2, 4 or 8");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("part_dcache: SETS must be a power of two, at least 2");
   end
   if (LINE_BYTES != 32) begin : g_bad_line
      $error("part_dcache: LINE_BYTES must be 32");
   end
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data
      $error("part_dcache: DATA_W must be 32 or 64");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("part_dcache: ADDR_W too small for the geometry");
   end

   pdc_state_e         state_q;
   logic [TAG_W-1:0]   rq_tag;
   logic [SET_W-1:0]   rq_set;
   logic [WORD_W-1:0]  rq_word;
   logic               rq_we;
   logic [DATA_W-1:0]  rq_wdata;
   logic [WAYS-1:0]    rq_emask;
   logic               rq_restrict;
   logic [IDX_W-1:0]   victim_q;
   logic [CNT_W-1:0]   cnt_q;

   logic [TAG_W-1:0]   tag_mem   [WAYS][SETS];
   logic               valid_mem [WAYS][SETS];
   logic               dirty_mem [WAYS][SETS];
   logic [DATA_W-1:0]  data_mem  [WAYS][SETS][WORDS];

   logic [WAYS-1:0][TAG_W-1:0]  way_tag_v;
   logic [WAYS-1:0]             way_valid_v;
   logic [WAYS-1:0][DATA_W-1:0] way_word_v;
   logic [WAYS-1:0]             act;
   logic [WAYS-1:0]             hit_vec;
   logic                        hit;
   logic [IDX_W-1:0]            hit_way;
   logic [DATA_W-1:0]           hit_word;
   logic [CNT_W-1:0]            act_cnt;
   logic [IDX_W-1:0]            victim;
   logic [LINE_W-1:0]           vic_line;
   logic [TAG_W-1:0]            vic_tag;
   logic                        accept;
   logic                        look_hit;
   logic                        fill_done;
   logic                        touch_en;
   logic [IDX_W-1:0]            touch_way;

   assign accept    = req_valid && req_ready;
   assign look_hit  = (state_q == ST_LOOK) && hit;
   assign fill_done = (state_q == ST_FILL) && mem_ready;
   assign touch_en  = look_hit || fill_done;
   assign touch_way = look_hit ? hit_way : victim_q;
   assign req_ready = (state_q == ST_IDLE);

   // Request capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rq_tag      <= '0;
         rq_set      <= '0;
         rq_word     <= '0;
         rq_we       <= 1'b0;
         rq_wdata    <= '0;
         rq_emask    <= {WAYS{1'b1}};
         rq_restrict <= 1'b0;
      end else if (accept) begin
         rq_tag      <= req_addr[ADDR_W-1 -: TAG_W];
         rq_set      <= req_addr[OFF_W +: SET_W];
         rq_word     <= req_addr[BYT_W +: WORD_W];
         rq_we       <= req_we;
         rq_wdata    <= req_wdata;
         rq_emask    <= (req_pmask == '0) ? {WAYS{1'b1}} : req_pmask;
         rq_restrict <= req_restrict;
      end
   end

   // Control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         victim_q <= '0;
         cnt_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) state_q <= ST_LOOK;
            ST_LOOK: begin
               cnt_q <= act_cnt;
               if (hit) begin
                  state_q <= ST_IDLE;
               end else begin
                  victim_q <= victim;
                  state_q  <= (valid_mem[victim][rq_set] && dirty_mem[victim][rq_set])
                              ? ST_WB : ST_FILL;
               end
            end
            ST_WB:   if (mem_ready) state_q <= ST_FILL;
            ST_FILL: if (mem_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Line state arrays
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) begin
               valid_mem[w][s] <= 1'b0;
               dirty_mem[w][s] <= 1'b0;
            end
      end else if (look_hit && rq_we) begin
         dirty_mem[hit_way][rq_set] <= 1'b1;
      end else if (fill_done) begin
         valid_mem[victim_q][rq_set] <= 1'b1;
         dirty_mem[victim_q][rq_set] <= rq_we;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) tag_mem[victim_q][rq_set] <= rq_tag;
   end

   always_ff @(posedge clk) begin
      if (look_hit && rq_we) begin
         data_mem[hit_way][rq_set][rq_word] <= rq_wdata;
      end else if (fill_done) begin
         for (int i = 0; i < WORDS; i++) begin
            data_mem[victim_q][rq_set][i] <= (rq_we && WORD_W'(i) == rq_word)
                                             ? rq_wdata : mem_rdata[i*DATA_W +: DATA_W];
         end
      end
   end

   // Per-set views
   for (genvar w = 0; w < WAYS; w++) begin : g_view
      assign way_tag_v[w]   = tag_mem[w][rq_set];
      assign way_valid_v[w] = valid_mem[w][rq_set];
      assign way_word_v[w]  = data_mem[w][rq_set][rq_word];
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_vline
      assign vic_line[i*DATA_W +: DATA_W] = data_mem[victim_q][rq_set][i];
   end
   assign vic_tag = tag_mem[victim_q][rq_set];

   pdc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
      .restrict_en (rq_restrict),
      .emask       (rq_emask),
      .look_tag    (rq_tag),
      .way_tag     (way_tag_v),
      .way_valid   (way_valid_v),
      .way_word    (way_word_v),
      .act         (act),
      .hit_vec     (hit_vec),
      .hit         (hit),
      .hit_way     (hit_way),
      .hit_word    (hit_word),
      .act_cnt     (act_cnt)
   );

   pdc_repl #(.WAYS(WAYS), .SETS(SETS)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (rq_set),
      .emask     (rq_emask),
      .way_valid (way_valid_v),
      .touch_en  (touch_en),
      .touch_set (rq_set),
      .touch_way (touch_way),
      .victim    (victim)
   );

   // Memory side
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {rq_tag, rq_set};
      mem_wdata = vic_line;
      if (state_q == ST_WB) begin
         mem_req  = 1'b1;
         mem_we   = 1'b1;
         mem_addr = {vic_tag, rq_set};
      end else if (state_q == ST_FILL) begin
         mem_req = 1'b1;
      end
   end

   // Response
   always_comb begin
      resp_valid = look_hit || fill_done;
      resp_hit   = look_hit;
      resp_way   = look_hit ? hit_way : victim_q;
      resp_rdata = look_hit ? hit_word : mem_rdata[rq_word*DATA_W +: DATA_W];
      resp_ways  = (state_q == ST_LOOK) ? act_cnt : cnt_q;
   end

   // Checks
   assert_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> req_addr[BYT_W-1:0] == '0);

   assert_restrict_in_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOOK && rq_restrict) |-> (hit_vec & ~rq_emask) == '0);

   assert_unrestricted_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOOK && !rq_restrict) |-> resp_ways == CNT_W'(WAYS));

   assert_victim_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL) |-> rq_emask[victim_q]);

   assert_wb_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (valid_mem[victim_q][rq_set] && dirty_mem[victim_q][rq_set]));

   assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

   assert_ready_after_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> req_ready);

endmodule

// File: tb/part_dcache_tb.sv
module part_dcache_tb;
   localparam int WAYS = 4;
   localparam int SETS = 2;
   localparam int AW   = 12;
   localparam int LW   = 256;
   localparam int NLN  = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_we = 1'b0;
   logic [31:0]   req_wdata = '0;
   logic [3:0]    req_pmask = '0;
   logic          req_restrict = 1'b0;
   logic          resp_valid, resp_hit;
   logic [31:0]   resp_rdata;
   logic [1:0]    resp_way;
   logic [2:0]    resp_ways;
   logic          mem_req, mem_we;
   logic [6:0]    mem_addr;
   logic [LW-1:0] mem_wdata, mem_rdata;
   logic          mem_ready = 1'b1;

   logic [LW-1:0] mem     [NLN];
   logic [LW-1:0] ref_mem [NLN];

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_req && mem_we && mem_ready) mem[mem_addr] <= mem_wdata;

   part_dcache #(.WAYS(WAYS), .SETS(SETS), .ADDR_W(AW), .DATA_W(32), .LINE_BYTES(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_pmask(req_pmask),
      .req_restrict(req_restrict), .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_rdata(resp_rdata), .resp_way(resp_way), .resp_ways(resp_ways),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready));

   int checks = 0;
   int fails  = 0;

   // Shadow state
   logic [5:0]  m_tag [WAYS][SETS];
   bit          m_val [WAYS][SETS];
   bit          m_dty [WAYS][SETS];
   int          m_age [WAYS][SETS];
   logic [31:0] m_dat [WAYS][SETS][8];

   task automatic chk(input string req, input string what, input logic [LW-1:0] act,
                      input logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] init_line(input int l);
      logic [LW-1:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'hA500_0000 ^ (l << 8) ^ i;
      return v;
   endfunction

   function automatic void m_touch(input int w, input int s);
      int a = m_age[w][s];
      for (int v = 0; v < WAYS; v++) begin
         if (v == w) m_age[v][s] = 0;
         else if (m_age[v][s] < a) m_age[v][s] = m_age[v][s] + 1;
      end
   endfunction

   task automatic access(input string req, input logic [AW-1:0] a, input bit we,
                         input logic [31:0] wd, input logic [3:0] pm, input bit rs);
      int s = int'(a[5]);
      logic [5:0] t = a[11:6];
      int wi = int'(a[4:2]);
      logic [3:0] em = (pm == 4'h0) ? 4'hF : pm;
      logic [3:0] actm = rs ? em : 4'hF;
      int cnt = $countones(actm);
      bit e_hit = 0;
      int e_way = 0;
      logic [31:0] e_rd = '0;
      bit e_wb = 0;
      logic [6:0] e_wba = '0;
      logic [LW-1:0] e_wbl = '0;
      int e_lat;
      int n = 0;
      int wb_seen = 0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (actm[w] && m_val[w][s] && m_tag[w][s] == t) begin e_hit = 1; e_way = w; end
      if (e_hit) begin
         e_lat = 1;
         if (we) begin m_dat[e_way][s][wi] = wd; m_dty[e_way][s] = 1; end
         else e_rd = m_dat[e_way][s][wi];
         m_touch(e_way, s);
      end else begin
         int vw = -1;
         logic [6:0] la = {t, a[5]};
         for (int w = WAYS - 1; w >= 0; w--) if (em[w] && !m_val[w][s]) vw = w;
         if (vw < 0)
            for (int w = 0; w < WAYS; w++)
               if (em[w] && (vw < 0 || m_age[w][s] > m_age[vw][s])) vw = w;
         e_way = vw;
         if (m_val[vw][s] && m_dty[vw][s]) begin
            e_wb = 1;
            e_wba = {m_tag[vw][s], a[5]};
            for (int i = 0; i < 8; i++) e_wbl[i*32 +: 32] = m_dat[vw][s][i];
            ref_mem[e_wba] = e_wbl;
            e_lat = 3;
         end else e_lat = 2;
         for (int i = 0; i < 8; i++) m_dat[vw][s][i] = ref_mem[la][i*32 +: 32];
         e_rd = m_dat[vw][s][wi];
         if (we) m_dat[vw][s][wi] = wd;
         m_dty[vw][s] = we;
         m_val[vw][s] = 1;
         m_tag[vw][s] = t;
         m_touch(vw, s);
      end

      @(negedge clk);
      chk("R9", "ready before request", req_ready, 1'b1);
      req_valid = 1; req_addr = a; req_we = we; req_wdata = wd;
      req_pmask = pm; req_restrict = rs;
      @(posedge clk);
      do begin
         @(negedge clk);
         req_valid = 0;
         n++;
         if (mem_req && mem_we) begin
            wb_seen++;
            chk("R7", "writeback address", mem_addr, e_wba);
            chk("R7", "writeback line", mem_wdata, e_wbl);
            chk("R7", "writeback precedes fill", wb_seen, 1);
         end
      end while (!resp_valid && n < 12);
      chk("R9", "response latency", n, e_lat);
      chk(req, "hit flag", resp_hit, e_hit);
      chk(req, "serving way", resp_way, e_way);
      chk(req, "activated ways", resp_ways, cnt);
      if (!we) chk(req, "read word", resp_rdata, e_rd);
      chk("R7", "writeback count", wb_seen, e_wb);
      @(negedge clk);
      chk("R9", "ready after response", req_ready, 1'b1);
      chk("R9", "single response pulse", resp_valid, 1'b0);
   endtask

   function automatic logic [AW-1:0] mk(input int tg, input int st, input int wd);
      return AW'((tg << 6) | (st << 5) | (wd << 2));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] rnd = 32'h1234_5678;
      for (int l = 0; l < NLN; l++) begin mem[l] = init_line(l); ref_mem[l] = init_line(l); end
      for (int w = 0; w < WAYS; w++)
         for (int s = 0; s < SETS; s++) begin
            m_val[w][s] = 0; m_dty[w][s] = 0; m_age[w][s] = w; m_tag[w][s] = '0;
         end
      repeat (3) @(negedge clk);
      chk("R1", "ready in reset release", req_ready, 1'b1);
      chk("R1", "resp idle", resp_valid, 1'b0);
      chk("R1", "mem idle", mem_req, 1'b0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "ready after reset", req_ready, 1'b1);

      // R1: first access misses; R5: single-way masks steer fills
      access("R1", mk(1, 0, 3), 0, 0, 4'b0001, 1);
      access("R5", mk(2, 0, 5), 0, 0, 4'b0010, 1);
      access("R5", mk(3, 0, 0), 0, 0, 4'b0100, 1);
      access("R5", mk(4, 0, 7), 0, 0, 4'b1000, 1);
      access("R11", mk(1, 0, 6), 0, 0, 4'b0001, 1);
      access("R10", mk(3, 0, 2), 0, 0, 4'b0100, 1);
      // R3: line in way 2 hits unrestricted with mask naming way 1
      access("R3", mk(3, 0, 1), 0, 0, 4'b0010, 0);
      // R2: same line restricted to way 1 misses
      access("R2", mk(3, 0, 4), 0, 0, 4'b0010, 1);
      access("R2", mk(4, 0, 7), 0, 0, 4'b1100, 1);
      // R4: zero mask means every way
      access("R4", mk(4, 0, 1), 0, 0, 4'b0000, 1);
      // R6: LRU in set 1
      access("R6", mk(5, 1, 0), 0, 0, 4'b0000, 0);
      access("R6", mk(6, 1, 0), 0, 0, 4'b0000, 0);
      access("R6", mk(7, 1, 0), 0, 0, 4'b0000, 0);
      access("R6", mk(8, 1, 0), 0, 0, 4'b0000, 0);
      access("R6", mk(5, 1, 1), 0, 0, 4'b0000, 0);
      access("R6", mk(7, 1, 1), 0, 0, 4'b0000, 0);
      access("R6", mk(9, 1, 2), 0, 0, 4'b0101, 1);
      access("R6", mk(10, 1, 2), 0, 0, 4'b0000, 1);
      // R8 then R7: store miss, read back, dirty eviction
      access("R8", mk(11, 1, 3), 1, 32'hCAFE_0011, 4'b1000, 1);
      access("R8", mk(11, 1, 3), 0, 0, 4'b1000, 1);
      access("R8", mk(11, 1, 4), 1, 32'hBEEF_0022, 4'b1000, 1);
      access("R7", mk(12, 1, 0), 0, 0, 4'b1000, 1);
      access("R7", mk(11, 1, 4), 0, 0, 4'b0001, 1);

      // Sweep
      for (int k = 0; k < 1500; k++) begin
         rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
         access("R2", mk(int'(rnd[2:0]) % 6, int'(rnd[3]), int'(rnd[6:4])),
                rnd[7] & rnd[8], rnd, rnd[12:9], rnd[13]);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule